// File: doc/BRIEF.md
# Per-Port Storm Control Credit Limiter

This block sits on the receive side of one switch port and decides, frame by frame, whether a received frame may proceed. An external classifier presents each frame once, as a single-cycle strobe with a class code: unicast, multicast or broadcast. The limiter keeps a separate credit counter for each of the three classes. A frame of a limited class is accepted while its counter is nonzero, and accepting it uses one credit. A frame that finds its counter at zero is dropped.

Credits come back only when an external timer sends a refill pulse. The pulse restores every counter to its programmed credit value, so the period of the pulse and the credit value together set the accepted rate. An accepted frame is released to both the host path and the cut-through path. A dropped frame goes to neither path, is kept out of the valid-frame statistics, and is counted in a saturating drop counter. Limiting can be turned off for the whole port or for each class on its own. Each port of a switch gets its own instance.

Top module: `storm_credit_limiter`

## Requirements
- R1: When a frame of limited class c arrives and the credit count of c is nonzero, the frame is accepted and the count of c drops by one. The class code is 2'b00 unicast, 2'b01 multicast and 2'b10 broadcast. The counts of the other classes are unchanged.
- R2: When a frame of limited class c arrives and the credit count of c is zero, the frame is dropped and the count stays at zero.
- R3: A `refill` pulse reloads all three counts to their programmed credit values. A frame in the same cycle is judged on the count before the reload, and the reload wins over that frame's decrement.
- R4: A `cred_wr` pulse sets the programmed credit value of the class selected by `cred_sel` (same class code; 2'b11 selects nothing) to `cred_val` and reloads that class's count to this value at once. The write wins over a refill or a decrement in the same cycle. A frame in the same cycle is judged on the old count.
- R5: `class_en` bit 0 enables unicast limiting, bit 1 multicast and bit 2 broadcast, each on its own. A frame of a disabled class is always accepted and leaves its count unchanged.
- R6: With `port_en` low, every frame is accepted and no count changes.
- R7: One cycle after a frame strobe, `to_host` and `to_cut` are both high if the frame was accepted. If it was dropped, both are low and `drop_stb` is high. In a cycle with no frame strobe, all three are low one cycle later.
- R8: `drop_cnt` (DROP_W bits, 32 by default) is 0 after reset. It rises by one in the same cycle that `drop_stb` goes high, and it holds at its all-ones value once it reaches it.
- R9: Class code 2'b11 is never limited. Such a frame is always accepted and changes no count.
- R10: After reset, every programmed credit value and every count equals the parameter CRED_RST, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Enables limiting on this port |
| class_en | input | 3 | Per-class limit enables (bit 0 unicast, bit 1 multicast, bit 2 broadcast) |
| frame_valid | input | 1 | One-cycle strobe that presents a received frame |
| frame_class | input | 2 | Class code of the presented frame |
| cred_wr | input | 1 | Credit value write strobe |
| cred_sel | input | 2 | Class whose credit value is written |
| cred_val | input | CRED_W | New credit value |
| refill | input | 1 | Periodic refill pulse from the external timer |
| to_host | output | 1 | Accepted frame is released toward the host |
| to_cut | output | 1 | Accepted frame is released to the cut-through path |
| drop_stb | output | 1 | Frame was dropped by the limiter |
| drop_cnt | output | DROP_W | Saturating count of dropped frames |

## Verification
The bench goes after the cycle where a refill or a credit write coincides with a frame. A design that applied the reload first would accept a frame that should have been dropped. A design that let the decrement win would start the new period one credit short. The bench disables a class, sends a burst of that class, then re-enables the class and counts the accepts before the first drop. A design that consumed credit while the class was disabled would drop that frame early. The bench also checks that one class running out of credit leaves the other two untouched, that class code 2'b11 is never limited, and that the drop counter stops at all-ones rather than wrapping to zero.

// File: rtl/stc_pkg.sv
package stc_pkg;
    typedef enum logic [1:0] {
        FC_UNI   = 2'b00,
        FC_MULTI = 2'b01,
        FC_BCAST = 2'b10,
        FC_RSVD  = 2'b11
    } fclass_e;

    localparam int NCLS = 3;

    typedef struct packed {
        logic to_host;
        logic to_cut;
        logic drop;
    } verdict_t;
endpackage

// File: rtl/stc_credit_slot.sv
module stc_credit_slot #(
    parameter int CRED_W   = 16,
    parameter int CRED_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CRED_W-1:0] wr_val,
    input  logic              refill,
    input  logic              consume,
    output logic              has_credit
);
    typedef struct packed {
        logic [CRED_W-1:0] prog;
        logic [CRED_W-1:0] cnt;
    } slot_t;

    localparam logic [CRED_W-1:0] RST_VAL = CRED_W'(CRED_RST);

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr) begin
            s_d.prog = wr_val;
            s_d.cnt  = wr_val;
        end else if (refill) begin
            s_d.cnt = s_q.prog;
        end else if (consume && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.prog <= RST_VAL;
            s_q.cnt  <= RST_VAL;
        end else begin
            s_q <= s_d;
        end
    end

    assign has_credit = (s_q.cnt != '0);

    // R1: a consumed credit lowers the count by exactly one
    a_r1_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !wr && !refill && (s_q.cnt != '0)) |=> (s_q.cnt == $past(s_q.cnt) - 1'b1));

    // R2: an empty count never wraps
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !wr && !refill && (s_q.cnt == '0)) |=> (s_q.cnt == '0));

    // R3: refill restores the programmed value, ahead of any decrement
    a_r3_refill_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (refill && !wr) |=> (s_q.cnt == $past(s_q.prog)));

    // R4: a write loads value and count together
    a_r4_write_reload: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ((s_q.cnt == $past(wr_val)) && (s_q.prog == $past(wr_val))));

    // R5: without consume, refill or write the count holds
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!consume && !wr && !refill) |=> $stable(s_q.cnt));
endmodule

// File: rtl/stc_drop_ctr.sv
module stc_drop_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != '1)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    // R8: all-ones is sticky
    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1) |=> (cnt_q == '1));

    // R8: the count moves only on an increment request
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt_q));
endmodule

// File: rtl/storm_credit_limiter.sv
module storm_credit_limiter
    import stc_pkg::*;
#(
    parameter int CRED_W   = 16,
    parameter int CRED_RST = 4,
    parameter int DROP_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic [2:0]        class_en,
    input  logic              frame_valid,
    input  logic [1:0]        frame_class,
    input  logic              cred_wr,
    input  logic [1:0]        cred_sel,
    input  logic [CRED_W-1:0] cred_val,
    input  logic              refill,
    output logic              to_host,
    output logic              to_cut,
    output logic              drop_stb,
    output logic [DROP_W-1:0] drop_cnt
);
    logic [NCLS-1:0] hit, limited, consume, has_credit, wr_slot;
    logic            blocked;
    verdict_t        v_d, v_q;

    for (genvar i = 0; i < NCLS; i++) begin : g_slot
        assign hit[i]     = frame_valid && (frame_class == 2'(i));
        assign limited[i] = port_en && class_en[i];
        assign consume[i] = hit[i] && limited[i];
        assign wr_slot[i] = cred_wr && (cred_sel == 2'(i));

        stc_credit_slot #(
            .CRED_W  (CRED_W),
            .CRED_RST(CRED_RST)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr        (wr_slot[i]),
            .wr_val    (cred_val),
            .refill    (refill),
            .consume   (consume[i]),
            .has_credit(has_credit[i])
        );
    end

    always_comb begin
        blocked   = |(consume & ~has_credit);
        v_d         = '0;
        v_d.to_host = frame_valid && !blocked;
        v_d.to_cut  = frame_valid && !blocked;
        v_d.drop    = frame_valid && blocked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q <= v_d;
        end
    end

    stc_drop_ctr #(.W(DROP_W)) u_drop (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (v_d.drop),
        .cnt  (drop_cnt)
    );

    assign to_host  = v_q.to_host;
    assign to_cut   = v_q.to_cut;
    assign drop_stb = v_q.drop;

    // R7: a verdict is either release-to-both or drop
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(drop_stb && (to_host || to_cut)) && (to_host == to_cut));

    // R7: no frame strobe, no verdict next cycle
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> !(to_host || to_cut || drop_stb));

    // R6: with the port unlimited every frame is released
    a_r6_port_off: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !port_en) |=> (to_host && !drop_stb));

    // R9: reserved class is never dropped
    a_r9_rsvd_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && (frame_class == 2'b11)) |=> to_host);

    // R8: drop counter advances together with the drop strobe
    a_r8_count_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_stb && ($past(drop_cnt) != '1)) |-> (drop_cnt == $past(drop_cnt) + 1'b1));
endmodule

// File: tb/tb_storm_credit_limiter.sv
module tb_storm_credit_limiter;
    localparam int CRED_W   = 16;
    localparam int CRED_RST = 4;
    localparam int DROP_W   = 6;
    localparam logic [DROP_W-1:0] DMAX = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              port_en = 1'b1;
    logic [2:0]        class_en = 3'b111;
    logic              frame_valid = 1'b0;
    logic [1:0]        frame_class = 2'b00;
    logic              cred_wr = 1'b0;
    logic [1:0]        cred_sel = 2'b00;
    logic [CRED_W-1:0] cred_val = '0;
    logic              refill = 1'b0;
    logic              to_host, to_cut, drop_stb;
    logic [DROP_W-1:0] drop_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [CRED_W-1:0] m_cnt  [3];
    logic [CRED_W-1:0] m_prog [3];
    logic [DROP_W-1:0] m_drop;

    always #10 clk = ~clk;

    storm_credit_limiter #(
        .CRED_W(CRED_W), .CRED_RST(CRED_RST), .DROP_W(DROP_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .class_en(class_en),
        .frame_valid(frame_valid), .frame_class(frame_class),
        .cred_wr(cred_wr), .cred_sel(cred_sel), .cred_val(cred_val),
        .refill(refill), .to_host(to_host), .to_cut(to_cut),
        .drop_stb(drop_stb), .drop_cnt(drop_cnt)
    );

    function automatic logic is_limited(input logic [1:0] fc);
        return port_en && (fc != 2'b11) && class_en[fc];
    endfunction

    task automatic cyc(input logic fv, input logic [1:0] fc, input logic wr,
                       input logic [1:0] sel, input logic [CRED_W-1:0] val,
                       input logic rf, input string tag);
        logic pass, exp_drop;
        @(negedge clk);
        frame_valid = fv; frame_class = fc; cred_wr = wr;
        cred_sel = sel; cred_val = val; refill = rf;
        pass     = fv && (!is_limited(fc) || (m_cnt[fc] != 0));
        exp_drop = fv && !pass;
        for (int i = 0; i < 3; i++) begin
            if (wr && sel == 2'(i)) begin
                m_prog[i] = val; m_cnt[i] = val;
            end else if (rf) begin
                m_cnt[i] = m_prog[i];
            end else if (fv && fc == 2'(i) && is_limited(fc) && m_cnt[i] != 0) begin
                m_cnt[i] = m_cnt[i] - 1'b1;
            end
        end
        if (exp_drop && m_drop != DMAX) m_drop = m_drop + 1'b1;
        @(negedge clk);
        frame_valid = 1'b0; cred_wr = 1'b0; refill = 1'b0;
        checks++;
        if (to_host !== pass || to_cut !== pass || drop_stb !== exp_drop || drop_cnt !== m_drop) begin
            errors++;
            $display("FAIL %s: host=%0b cut=%0b drop=%0b cnt=%0d expected host=%0b cut=%0b drop=%0b cnt=%0d",
                     tag, to_host, to_cut, drop_stb, drop_cnt, pass, pass, exp_drop, m_drop);
        end
    endtask

    task automatic frame(input logic [1:0] fc, input string tag);
        cyc(1'b1, fc, 1'b0, 2'b00, '0, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < 3; i++) begin
            m_cnt[i] = CRED_RST; m_prog[i] = CRED_RST;
        end
        m_drop = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (to_host !== 1'b0 || to_cut !== 1'b0 || drop_stb !== 1'b0 || drop_cnt !== '0) begin
            errors++;
            $display("FAIL R10 reset: host=%0b cut=%0b drop=%0b cnt=%0d expected all 0",
                     to_host, to_cut, drop_stb, drop_cnt);
        end

        // R10, R1, R2: reset credit of 4 unicast, fifth drops
        for (int k = 0; k < 4; k++) frame(2'b00, "R1 R10 unicast within credit");
        frame(2'b00, "R2 unicast out of credit");
        frame(2'b00, "R2 unicast stays empty");
        // R1: other classes unaffected
        frame(2'b01, "R1 multicast independent");
        frame(2'b10, "R1 broadcast independent");
        // R7: idle cycle
        cyc(1'b0, 2'b00, 1'b0, 2'b00, '0, 1'b0, "R7 idle no verdict");
        // R3: refill then accept
        cyc(1'b0, 2'b00, 1'b0, 2'b00, '0, 1'b1, "R3 refill pulse");
        frame(2'b00, "R3 unicast after refill");
        // R3: drain, then frame on the refill cycle
        for (int k = 0; k < 3; k++) frame(2'b00, "R3 drain");
        cyc(1'b1, 2'b00, 1'b0, 2'b00, '0, 1'b1, "R3 frame with refill judged on old count");
        for (int k = 0; k < 5; k++) frame(2'b00, "R3 reload beat decrement");
        // R4: write with coincident frame and refill
        cyc(1'b1, 2'b01, 1'b1, 2'b01, 16'd2, 1'b1, "R4 write with frame and refill");
        for (int k = 0; k < 3; k++) frame(2'b01, "R4 new multicast credit");
        cyc(1'b0, 2'b00, 1'b1, 2'b11, 16'd9, 1'b0, "R4 reserved select writes nothing");
        cyc(1'b0, 2'b00, 1'b0, 2'b00, '0, 1'b1, "R4 refill uses written value");
        for (int k = 0; k < 3; k++) frame(2'b01, "R4 refill to written value");
        // R5: disabled broadcast leaves count alone
        class_en = 3'b011;
        for (int k = 0; k < 8; k++) frame(2'b10, "R5 broadcast disabled accepted");
        class_en = 3'b111;
        for (int k = 0; k < 6; k++) frame(2'b10, "R5 broadcast count untouched");
        // R6: port off
        port_en = 1'b0;
        for (int k = 0; k < 6; k++) frame(2'(k % 3), "R6 port unlimited");
        port_en = 1'b1;
        frame(2'b10, "R6 counts unchanged after port off");
        // R9: reserved class
        for (int k = 0; k < 6; k++) frame(2'b11, "R9 reserved never limited");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic fv, wr, rf;
            logic [1:0] fc, sel;
            logic [CRED_W-1:0] val;
            if ($urandom_range(0, 99) < 3) port_en = ~port_en;
            if ($urandom_range(0, 99) < 5) class_en = 3'($urandom_range(0, 7));
            fv  = ($urandom_range(0, 99) < 80);
            fc  = 2'($urandom_range(0, 3));
            wr  = ($urandom_range(0, 99) < 4);
            sel = 2'($urandom_range(0, 3));
            val = CRED_W'($urandom_range(0, 6));
            rf  = ($urandom_range(0, 99) < 6);
            cyc(fv, fc, wr, sel, val, rf, "R1 R2 R3 R4 R5 R6 R7 random");
        end

        // R8: saturation
        port_en = 1'b1; class_en = 3'b111;
        cyc(1'b0, 2'b00, 1'b1, 2'b00, '0, 1'b0, "R8 zero unicast credit");
        for (int k = 0; k < 70; k++) frame(2'b00, "R8 drop counter saturates");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule